// File: doc/BRIEF.md
# Illegal Opcode Exception Trap Unit

This unit sits next to the decode stage of a 32-bit RISC core and watches each instruction word that is actually being executed. A small set of encodings is reserved as illegal. When an instruction with one of these encodings executes, the unit performs trap entry on the next clock edge. Trap entry has four parts:

- The program counter to resume at is saved in a debug shadow register.
- The status word is saved, unmodified, in a second shadow register.
- Three mask bits are set in the new status word that the unit presents.
- The program counter is redirected to a fixed handler vector.

A one-cycle `trap_taken_o` pulse tells the pipeline to flush and to load the presented PC and status word.

An encoding is illegal when three fields all match:

- the primary opcode field is all ones;
- a 4-bit sub-opcode field holds a value of 7 or more;
- a single separator bit is clear.

Every other bit of the word is ignored. Fetching a matching word without executing it has no effect.

Top module: `illop_trap_unit`

## Requirements
- R1: A trap needs instruction bits [10:5] equal to 6'b111111. With any of those six bits clear, no trap is raised.
- R2: A trap needs the sub-opcode in bits [26:23] to be in the range 4'd7 to 4'd15 inclusive. Values 4'd0 to 4'd6 never trap.
- R3: A trap needs instruction bit 16 to be 0. With bit 16 set, no trap is raised.
- R4: Bits [31:27], [22:17], [15:11] and [4:0] have no effect on whether a trap is raised.
- R5: A trap is raised only when `exec_i` is 1 with a matching word. In that case `trap_taken_o` is 1 for exactly the one cycle after that clock edge. A matching word with `exec_i` at 0 leaves every output unchanged.
- R6: On trap entry, `dbpc_o` takes the value of `pc_i` that was sampled with the trapping instruction.
- R7: On trap entry, `dbpsw_o` takes the sampled `psw_i` with no bit changed.
- R8: On trap entry, `new_psw_o` equals the sampled `psw_i` with bits 7, 6 and 5 set to 1 and all other bits unchanged. Bit 7 is the no-preempt mask, bit 6 is the exception-pending flag and bit 5 is the interrupt-disable mask.
- R9: On trap entry, `new_pc_o` equals 32'h0000_0060.
- R10: After reset, `trap_taken_o` is 0 and `dbpc_o`, `dbpsw_o`, `new_pc_o` and `new_psw_o` are all 0. These four registers change only on trap entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_i | input | 32 | Instruction word in execute |
| exec_i | input | 1 | The word in `insn_i` executes this cycle |
| pc_i | input | 32 | PC to restore after the handler |
| psw_i | input | 32 | Current status word |
| trap_taken_o | output | 1 | One-cycle trap entry pulse |
| new_pc_o | output | 32 | PC to load (handler vector) |
| new_psw_o | output | 32 | Status word to load |
| dbpc_o | output | 32 | Saved restore PC |
| dbpsw_o | output | 32 | Saved status word |

## Verification
Every result is due one clock after the stimulus. `insn_i`, `exec_i`, `pc_i` and `psw_i` are sampled on a rising edge. `trap_taken_o`, `new_pc_o`, `new_psw_o`, `dbpc_o` and `dbpsw_o` all change at that same edge.

The bench drives inputs on the falling edge and waits for the next rising edge. It samples 1 ns later and compares every output there. After each step it drops `exec_i` so that a stale strobe cannot raise a trap.

When no trap is expected, the bench checks that the shadow and load registers still hold the values from the last trap its own model recorded.

// File: rtl/illop_pkg.sv
package illop_pkg;

  localparam int unsigned XLEN = 32;

  // Bit mask of the bits that trap entry forces to one.
  function automatic logic [XLEN-1:0] trap_set_mask(input int unsigned np_bit,
                                                    input int unsigned ep_bit,
                                                    input int unsigned id_bit);
    logic [XLEN-1:0] m;
    m = '0;
    m[np_bit] = 1'b1;
    m[ep_bit] = 1'b1;
    m[id_bit] = 1'b1;
    return m;
  endfunction

  // Pulls an unsigned field out of a word.
  function automatic logic [XLEN-1:0] field_of(input logic [XLEN-1:0] word,
                                               input int unsigned lsb,
                                               input int unsigned width);
    logic [XLEN-1:0] ones;
    ones = (XLEN'(1) << width) - XLEN'(1);
    return (word >> lsb) & ones;
  endfunction

endpackage

// File: rtl/illop_match.sv
module illop_match
  import illop_pkg::*;
#(
  parameter int unsigned OPC_LSB = 5,
  parameter int unsigned OPC_W   = 6,
  parameter int unsigned SUB_LSB = 23,
  parameter int unsigned SUB_W   = 4,
  parameter int unsigned SUB_MIN = 7,
  parameter int unsigned SEP_BIT = 16
) (
  input  logic [XLEN-1:0] insn_i,
  output logic            opc_hit_o,
  output logic            sub_hit_o,
  output logic            sep_hit_o,
  output logic            match_o
);
  localparam logic [XLEN-1:0] OPC_ALL = (XLEN'(1) << OPC_W) - XLEN'(1);

  logic [XLEN-1:0] opc_f;
  logic [XLEN-1:0] sub_f;

  assign opc_f     = field_of(insn_i, OPC_LSB, OPC_W);
  assign sub_f     = field_of(insn_i, SUB_LSB, SUB_W);
  assign opc_hit_o = (opc_f == OPC_ALL);
  assign sep_hit_o = ~insn_i[SEP_BIT];

  generate
    if (SUB_MIN == 0) begin : g_sub_any
      assign sub_hit_o = 1'b1;
    end else begin : g_sub_cmp
      assign sub_hit_o = (sub_f >= XLEN'(SUB_MIN));
    end
  endgenerate

  assign match_o = opc_hit_o & sub_hit_o & sep_hit_o;
endmodule

// File: rtl/illop_psw_mask.sv
module illop_psw_mask
  import illop_pkg::*;
#(
  parameter int unsigned NP_BIT = 7,
  parameter int unsigned EP_BIT = 6,
  parameter int unsigned ID_BIT = 5
) (
  input  logic [XLEN-1:0] psw_i,
  output logic [XLEN-1:0] psw_o
);
  localparam logic [XLEN-1:0] SET_M = trap_set_mask(NP_BIT, EP_BIT, ID_BIT);

  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    if (SET_M[b]) begin : g_force
      assign psw_o[b] = 1'b1;
    end else begin : g_pass
      assign psw_o[b] = psw_i[b];
    end
  end
endmodule

// File: rtl/illop_shadow.sv
module illop_shadow
  import illop_pkg::*;
#(
  parameter logic [XLEN-1:0] VECTOR = 32'h0000_0060
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] psw_i,
  input  logic [XLEN-1:0] psw_masked_i,
  output logic            trap_taken_o,
  output logic [XLEN-1:0] new_pc_o,
  output logic [XLEN-1:0] new_psw_o,
  output logic [XLEN-1:0] dbpc_o,
  output logic [XLEN-1:0] dbpsw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_taken_o <= 1'b0;
      new_pc_o     <= '0;
      new_psw_o    <= '0;
      dbpc_o       <= '0;
      dbpsw_o      <= '0;
    end else begin
      trap_taken_o <= take_i;
      if (take_i) begin
        dbpc_o    <= pc_i;
        dbpsw_o   <= psw_i;
        new_psw_o <= psw_masked_i;
        new_pc_o  <= VECTOR;
      end
    end
  end
endmodule

// File: rtl/illop_trap_unit.sv
module illop_trap_unit
  import illop_pkg::*;
#(
  parameter int unsigned      OPC_LSB = 5,
  parameter int unsigned      OPC_W   = 6,
  parameter int unsigned      SUB_LSB = 23,
  parameter int unsigned      SUB_W   = 4,
  parameter int unsigned      SUB_MIN = 7,
  parameter int unsigned      SEP_BIT = 16,
  parameter int unsigned      NP_BIT  = 7,
  parameter int unsigned      EP_BIT  = 6,
  parameter int unsigned      ID_BIT  = 5,
  parameter logic [XLEN-1:0]  VECTOR  = 32'h0000_0060
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] insn_i,
  input  logic            exec_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] psw_i,
  output logic            trap_taken_o,
  output logic [XLEN-1:0] new_pc_o,
  output logic [XLEN-1:0] new_psw_o,
  output logic [XLEN-1:0] dbpc_o,
  output logic [XLEN-1:0] dbpsw_o
);
  // Named internal events, brought out for the checker.
  logic            opc_hit_w;
  logic            sub_hit_w;
  logic            sep_hit_w;
  logic            match_w;
  logic            take_w;
  logic [XLEN-1:0] psw_masked_w;

  illop_match #(
    .OPC_LSB(OPC_LSB), .OPC_W(OPC_W), .SUB_LSB(SUB_LSB),
    .SUB_W(SUB_W), .SUB_MIN(SUB_MIN), .SEP_BIT(SEP_BIT)
  ) u_match (
    .insn_i   (insn_i),
    .opc_hit_o(opc_hit_w),
    .sub_hit_o(sub_hit_w),
    .sep_hit_o(sep_hit_w),
    .match_o  (match_w)
  );

  assign take_w = exec_i & match_w;

  illop_psw_mask #(
    .NP_BIT(NP_BIT), .EP_BIT(EP_BIT), .ID_BIT(ID_BIT)
  ) u_mask (
    .psw_i(psw_i),
    .psw_o(psw_masked_w)
  );

  illop_shadow #(
    .VECTOR(VECTOR)
  ) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take_w),
    .pc_i        (pc_i),
    .psw_i       (psw_i),
    .psw_masked_i(psw_masked_w),
    .trap_taken_o(trap_taken_o),
    .new_pc_o    (new_pc_o),
    .new_psw_o   (new_psw_o),
    .dbpc_o      (dbpc_o),
    .dbpsw_o     (dbpsw_o)
  );
endmodule

// File: rtl/illop_trap_unit_chk.sv
module illop_trap_unit_chk
  import illop_pkg::*;
#(
  parameter int unsigned NP_BIT = 7,
  parameter int unsigned EP_BIT = 6,
  parameter int unsigned ID_BIT = 5,
  parameter logic [XLEN-1:0] VECTOR = 32'h0000_0060
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            exec_i,
  input logic            match_w,
  input logic            opc_hit_w,
  input logic            sub_hit_w,
  input logic            sep_hit_w,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] psw_i,
  input logic            trap_taken_o,
  input logic [XLEN-1:0] new_pc_o,
  input logic [XLEN-1:0] new_psw_o,
  input logic [XLEN-1:0] dbpc_o,
  input logic [XLEN-1:0] dbpsw_o
);
  localparam logic [XLEN-1:0] SET_M = trap_set_mask(NP_BIT, EP_BIT, ID_BIT);

  // R5: no strobe, no pulse on the next cycle
  p_no_exec_no_trap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> !trap_taken_o);

  // R5: a pulse always follows an executed match
  p_match_gives_trap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && match_w) |=> trap_taken_o);

  // R1, R2, R3: a pulse needs all three field hits in the previous cycle
  p_fields_all_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_taken_o |-> $past(opc_hit_w && sub_hit_w && sep_hit_w));

  // R6
  p_dbpc_saved_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_taken_o |-> dbpc_o == $past(pc_i));

  // R7
  p_dbpsw_saved_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_taken_o |-> dbpsw_o == $past(psw_i));

  // R8
  p_psw_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_taken_o |-> ((new_psw_o & SET_M) == SET_M) &&
                     ((new_psw_o & ~SET_M) == ($past(psw_i) & ~SET_M)));

  // R9
  p_vector_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_taken_o |-> new_pc_o == VECTOR);

  // R10: the saved registers hold between traps
  p_shadow_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_taken_o |-> $stable(dbpc_o) && $stable(dbpsw_o) &&
                      $stable(new_pc_o) && $stable(new_psw_o));
endmodule

bind illop_trap_unit illop_trap_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exec_i      (exec_i),
  .match_w     (match_w),
  .opc_hit_w   (opc_hit_w),
  .sub_hit_w   (sub_hit_w),
  .sep_hit_w   (sep_hit_w),
  .pc_i        (pc_i),
  .psw_i       (psw_i),
  .trap_taken_o(trap_taken_o),
  .new_pc_o    (new_pc_o),
  .new_psw_o   (new_psw_o),
  .dbpc_o      (dbpc_o),
  .dbpsw_o     (dbpsw_o)
);

// File: tb/illop_trap_unit_test.sv
`timescale 1ns/1ps
module illop_trap_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] insn_i = '0;
  logic        exec_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic [31:0] psw_i = '0;
  logic        trap_taken_o;
  logic [31:0] new_pc_o, new_psw_o, dbpc_o, dbpsw_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Bench-side model of the last trap entry.
  logic [31:0] m_pc = '0, m_psw = '0, m_npc = '0, m_npsw = '0;

  illop_trap_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .insn_i(insn_i), .exec_i(exec_i),
    .pc_i(pc_i), .psw_i(psw_i), .trap_taken_o(trap_taken_o),
    .new_pc_o(new_pc_o), .new_psw_o(new_psw_o),
    .dbpc_o(dbpc_o), .dbpsw_o(dbpsw_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference decision: opcode all ones, sub >= 7 means bit26 set or bits 25:23 all set.
  function automatic bit ref_illegal(input logic [31:0] w);
    return (&w[10:5]) && (w[26] || (&w[25:23])) && !w[16];
  endfunction

  // One execute step, results sampled 1 ns after the next rising edge.
  task automatic step(input logic [31:0] w, input logic ex, input logic [31:0] pc,
                      input logic [31:0] psw, input string req);
    bit hit;
    @(negedge clk_i);
    insn_i = w; exec_i = ex; pc_i = pc; psw_i = psw;
    hit = ex && ref_illegal(w);
    if (hit) begin
      m_pc = pc; m_psw = psw; m_npc = 32'h0000_0060;
      m_npsw = psw | 32'h0000_00E0;
    end
    @(posedge clk_i); #1;
    exec_i = 1'b0;
    check({req, " trap_taken"}, {31'd0, trap_taken_o}, {31'd0, hit});
    check({req, " dbpc R6"},    dbpc_o,    m_pc);
    check({req, " dbpsw R7"},   dbpsw_o,   m_psw);
    check({req, " new_psw R8"}, new_psw_o, m_npsw);
    check({req, " new_pc R9"},  new_pc_o,  m_npc);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    #12;
    check("R10 reset trap", {31'd0, trap_taken_o}, 32'd0);
    check("R10 reset dbpc", dbpc_o, 32'd0);
    check("R10 reset dbpsw", dbpsw_o, 32'd0);
    check("R10 reset new_pc", new_pc_o, 32'd0);
    check("R10 reset new_psw", new_psw_o, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_sub_sweep;
    for (int s = 0; s < 16; s++) begin
      for (int b = 0; b < 2; b++) begin
        logic [31:0] w;
        w = 32'h0000_07E0;
        w[26:23] = 4'(s);
        w[16] = 1'(b);
        step(w, 1'b1, 32'h1000_0000 + 32'(s * 4 + b), 32'hA5A5_0000 + 32'(s),
             (b == 0) ? "R2 sub sweep" : "R3 sep bit set");
      end
    end
  endtask

  task automatic t_near_miss;
    for (int k = 5; k <= 10; k++) begin
      logic [31:0] w;
      w = 32'h0780_07E0;
      w[k] = 1'b0;
      step(w, 1'b1, 32'h2000_0000 + 32'(k), 32'h0000_1F00, "R1 opcode near miss");
    end
    step(32'h0780_07E0, 1'b1, 32'h2000_0100, 32'hFFFF_FF1F, "R1 full opcode");
  endtask

  task automatic t_dont_care;
    // bits 31:27, 22:17, 15:11, 4:0 set and cleared
    step(32'hF87E_F81F | 32'h0380_07E0, 1'b1, 32'h3000_0004, 32'h0000_0000, "R4 dc ones");
    step(32'h0380_07E0, 1'b1, 32'h3000_0008, 32'h8000_0001, "R4 dc zeros");
    step(32'h5A2A_A80A | 32'h0400_07E0, 1'b1, 32'h3000_000C, 32'h1234_5678, "R4 dc mixed");
  endtask

  task automatic t_no_exec;
    step(32'h0780_07E0, 1'b0, 32'h4000_0000, 32'hDEAD_BEEF, "R5 no exec");
    step(32'h0780_07E0, 1'b1, 32'h4000_0010, 32'h0000_0020, "R5 exec");
    step(32'h0000_0000, 1'b0, 32'h4000_0020, 32'h0000_0000, "R5 pulse ends");
    step(32'h0780_07E0, 1'b1, 32'h4000_0030, 32'h0000_00E0, "R5 back to back a");
    step(32'h03C0_07E0, 1'b1, 32'h4000_0034, 32'h7FFF_FF00, "R5 back to back b");
  endtask

  initial begin
    t_reset();
    t_sub_sweep();
    t_near_miss();
    t_dont_care();
    t_no_exec();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule